// File: doc/BRIEF.md
# Framed PCM Serial Sample Port

This block moves 8-bit companded PCM samples between a framed telephony serial bus and per-channel sample registers. Each channel has one serial receive input and one serial transmit output. Every channel shares a single bit clock and a single frame timing. The samples are opaque bytes: companding and any tone processing happen elsewhere.

The port has two clock modes, and `ext_mode` switches between them at run time.

- **Internal mode.** The port divides the system clock by `DIV` to make the bit clock. It builds a frame of `FRAME_BITS` bit slots and drives an active-high frame pulse during slot 0. Receive and transmit shift together in the slots that follow the pulse.
- **External mode.** The port follows an external bit clock and two separate active-low strobes, one for receive and one for transmit. The falling edge of a strobe starts its transfer. The rising edge finishes it: on the receive side it delivers the captured sample, and on the transmit side it takes the next outbound sample.

Tri-state pins are modelled as a data signal plus an output enable.

Top module: `pcm_serial_port`

## Requirements
- R1: In internal mode, after reset, `sclk_oe` is high. `sclk_out` is high for the first DIV/2 system clocks of each DIV-clock bit period and low for the rest. Bit periods count from the first clock after reset, or from the clock that completes a switch into internal mode.
- R2: In internal mode, `frame_out` is high for the whole of bit slot 0 of every FRAME_BITS-slot frame and low in every other slot. In external mode, `frame_out` and `sclk_oe` stay low.
- R3: In internal mode, `dr[c]` is sampled at the falling bit-clock edge of slots 1 to W, with the first sample being the most significant bit. One clock after the slot-W falling edge, `rx_valid` pulses for exactly one clock, and `rx_data[c*W +: W]` holds the new sample.
- R4: In internal mode, `tx_data` is captured as slot 0 begins, and `tx_taken` pulses for one clock at that point. The captured value is sent most significant bit first, one bit per slot, in slots 1 to W. `dx_oe` is high in exactly those slots. The first frame after reset sends zeros.
- R5: In external mode, a falling `fsx_n` enables `dx_oe` and drives the sample's most significant bit. Each following rising edge of `sclk_in` advances one bit. The W-th rising edge turns `dx_oe` off.
- R6: In external mode, a rising `fsx_n` captures `tx_data` for the next transfer and pulses `tx_taken`. A change on `tx_data` during a transfer does not alter the bits being sent.
- R7: In external mode, a falling `fsr_n` arms capture. The next W falling edges of `sclk_in` sample `dr`, most significant bit first. The value of `dr` around a rising edge is ignored. `rx_data` and `rx_valid` change only one clock after `fsr_n` rises, with `rx_valid` high for a single clock.
- R8: While `rst_n` is low, `sclk_oe`, `dx_oe`, `frame_out`, `rx_valid` and `tx_taken` are low, and `rx_data` is zero.
- R9: A change of `ext_mode` aborts any transfer in progress: `dx_oe` is low one clock later. On a switch into internal mode, bit and frame timing restart at the start of slot 0.
- R10: Channel c uses `dr[c]`, `dx[c]` and bits `[c*W +: W]` of `rx_data` and `tx_data`. The receive strobe alone never starts a transmit transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 = follow external bit clock and strobes, 0 = generate timing |
| sclk_in | input | 1 | External bit clock |
| fsr_n | input | 1 | External receive frame strobe, active low |
| fsx_n | input | 1 | External transmit frame strobe, active low |
| dr | input | N_CH | Serial receive data, one line per channel |
| tx_data | input | N_CH*W | Next outbound samples, channel c at [c*W +: W] |
| sclk_out | output | 1 | Generated bit clock |
| sclk_oe | output | 1 | Output enable for the generated bit clock |
| frame_out | output | 1 | Generated frame pulse, active high |
| dx | output | N_CH | Serial transmit data, one line per channel |
| dx_oe | output | N_CH | Output enable per transmit line |
| rx_data | output | N_CH*W | Last delivered received samples |
| rx_valid | output | 1 | One-clock strobe: new received samples |
| tx_taken | output | 1 | One-clock strobe: outbound samples captured |

## Verification
The bench builds the port with DIV=4 and FRAME_BITS=16. A frame is then 64 system clocks long, so a short run covers several internal frames, a mode switch in the middle of a transfer, two external transfers and a return to internal timing. W=8 and N_CH=2 keep the default sample width. The two channels carry different values, so swapped lanes and bit order errors show up. The bench changes receive data at rising bit-clock edges, which exposes sampling on the wrong edge. The defaults, DIV=10 and FRAME_BITS=256, only stretch the same counters.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int N_CH       = 2,
  parameter int W          = 8,
  parameter int DIV        = 10,
  parameter int FRAME_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_mode,
  input  logic                sclk_in,
  input  logic                fsr_n,
  input  logic                fsx_n,
  input  logic [N_CH-1:0]     dr,
  input  logic [N_CH*W-1:0]   tx_data,
  output logic                sclk_out,
  output logic                sclk_oe,
  output logic                frame_out,
  output logic [N_CH-1:0]     dx,
  output logic [N_CH-1:0]     dx_oe,
  output logic [N_CH*W-1:0]   rx_data,
  output logic                rx_valid,
  output logic                tx_taken
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [DW-1:0] D_LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] D_HALF = DW'(DIV / 2 - 1);
  localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] C_LAST = CW'(W - 1);

  logic [DW-1:0] dcnt;
  logic [BW-1:0] bcnt;
  logic          alive, ext_q, sclk_q, fsr_q, fsx_q;
  logic          rx_act, tx_act;
  logic [CW-1:0] rx_cnt, tx_cnt;

  wire mode_chg = ext_q != ext_mode;
  wire int_rise = dcnt == D_LAST;
  wire int_fall = dcnt == D_HALF;
  wire rise     = !mode_chg && (ext_mode ? (sclk_in && !sclk_q) : int_rise);
  wire fall     = !mode_chg && (ext_mode ? (!sclk_in && sclk_q) : int_fall);
  wire rx_start = !mode_chg && (ext_mode ? (!fsr_n && fsr_q) : (int_rise && bcnt == '0));
  wire tx_start = !mode_chg && (ext_mode ? (!fsx_n && fsx_q) : (int_rise && bcnt == '0));
  wire tx_load  = !mode_chg && (ext_mode ? (fsx_n && !fsx_q) : (int_rise && bcnt == B_LAST));
  wire rx_last  = fall && rx_act && rx_cnt == C_LAST;
  wire rx_commit = !mode_chg && (ext_mode ? (fsr_n && !fsr_q) : rx_last);

  assign sclk_oe   = alive && !ext_mode;
  assign sclk_out  = sclk_oe && (dcnt <= D_HALF);
  assign frame_out = sclk_oe && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0; bcnt <= '0; alive <= 1'b0; ext_q <= 1'b0;
      sclk_q <= 1'b0; fsr_q <= 1'b1; fsx_q <= 1'b1;
      rx_act <= 1'b0; tx_act <= 1'b0; rx_cnt <= '0; tx_cnt <= '0;
      rx_valid <= 1'b0; tx_taken <= 1'b0;
    end else begin
      alive    <= 1'b1;
      ext_q    <= ext_mode;
      sclk_q   <= sclk_in;
      fsr_q    <= fsr_n;
      fsx_q    <= fsx_n;
      rx_valid <= rx_commit;
      tx_taken <= tx_load;
      if (mode_chg) begin
        dcnt <= '0; bcnt <= '0; rx_act <= 1'b0; tx_act <= 1'b0;
      end else begin
        dcnt <= int_rise ? '0 : dcnt + 1'b1;
        if (int_rise) bcnt <= (bcnt == B_LAST) ? '0 : bcnt + 1'b1;
        if (rx_start) begin
          rx_act <= 1'b1; rx_cnt <= '0;
        end else if (fall && rx_act) begin
          if (rx_cnt == C_LAST) rx_act <= 1'b0;
          else rx_cnt <= rx_cnt + 1'b1;
        end
        if (tx_start) begin
          tx_act <= 1'b1; tx_cnt <= '0;
        end else if (rise && tx_act) begin
          if (tx_cnt == C_LAST) tx_act <= 1'b0;
          else tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [W-1:0] rsr, rhold, tsr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsr <= '0; rhold <= '0; tsr <= '0;
      end else begin
        if (fall && rx_act) rsr <= {rsr[W-2:0], dr[c]};
        if (rx_commit) rhold <= ext_mode ? rsr : {rsr[W-2:0], dr[c]};
        if (tx_load) tsr <= tx_data[c*W +: W];
      end
    end
    assign rx_data[c*W +: W] = rhold;
    assign dx[c]    = tsr[C_LAST - tx_cnt];
    assign dx_oe[c] = tx_act;
  end

  // R3 / R7: delivery strobe never lasts two clocks
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7: delivered samples only change on a commit
  a_r7_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_commit) |-> $stable(rx_data));
  // R5: a transmit bit holds between bit-clock rising edges
  a_r5_dx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe[0] && $past(dx_oe[0]) && !$past(rise) && !$past(tx_start) && !$past(tx_load))
      |-> $stable(dx[0]));
  // R9: mode change releases the transmit lines
  a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != $past(ext_mode)) |=> (dx_oe == '0));
  // R2: the frame pulse spans more than one clock
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |=> (frame_out || ext_mode));
endmodule

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
  localparam int N = 2, W = 8, DIV = 4, FB = 16, P = DIV * FB;

  logic clk = 1'b0, rst_n = 1'b0, ext_mode = 1'b0;
  logic sclk_in = 1'b0, fsr_n = 1'b1, fsx_n = 1'b1;
  logic [N-1:0] dr = '0;
  logic [N*W-1:0] tx_data;
  logic sclk_out, sclk_oe, frame_out, rx_valid, tx_taken;
  logic [N-1:0] dx, dx_oe;
  logic [N*W-1:0] rx_data;

  int errs = 0, checks = 0, k = 0;
  logic [N*W-1:0] cur_tx, exp_sr;

  pcm_serial_port #(.N_CH(N), .W(W), .DIV(DIV), .FRAME_BITS(FB)) uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sclk_in(sclk_in),
    .fsr_n(fsr_n), .fsx_n(fsx_n), .dr(dr), .tx_data(tx_data),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .frame_out(frame_out),
    .dx(dx), .dx_oe(dx_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_taken(tx_taken));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [N*W-1:0] rxpat(input int f);
    return {8'(f * 29 + 8'h6B), 8'(f * 53 + 8'hC4)};
  endfunction

  task automatic drive_dr;
    int s;
    logic [N*W-1:0] p;
    s = (k / DIV) % FB;
    p = rxpat(k / P);
    if (s >= 1 && s <= W) begin
      for (int c = 0; c < N; c++) dr[c] = p[c*W + W - s];
    end else dr = N'(k);
  endtask

  task automatic run_int(input int n);
    int s, ph;
    logic taken, vld;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); k++; @(negedge clk);
      taken = (k > 0 && k % P == 0);
      if (taken) exp_sr = cur_tx;
      s = (k / DIV) % FB;
      ph = k % DIV;
      check("R1 bit clock", {sclk_oe, sclk_out}, {1'b1, ph < DIV / 2});
      check("R2 frame pulse", frame_out, s == 0);
      check("R4 tx enable", dx_oe, (s >= 1 && s <= W) ? 2'b11 : 2'b00);
      if (s >= 1 && s <= W)
        check("R4 R10 tx bit", dx, {exp_sr[W + W - s], exp_sr[W - s]});
      check("R4 tx_taken", tx_taken, taken);
      vld = (k % P == W * DIV + DIV / 2);
      check("R3 rx_valid", rx_valid, vld);
      if (vld) check("R3 R10 rx data", rx_data, rxpat(k / P));
      if (k % P == P / 2) begin
        cur_tx = {cur_tx[N*W-2:0], cur_tx[N*W-1]} ^ 16'h1D3B;
        tx_data = cur_tx;
      end
      drive_dr();
    end
  endtask

  task automatic ext_xfer(input logic [N*W-1:0] rxv, input logic [N*W-1:0] nxt);
    logic [N-1:0] b;
    sclk_in = 1'b1; tx_data = nxt; cur_tx = nxt; tick();
    fsx_n = 1'b0; fsr_n = 1'b0; tick();
    for (int i = 0; i < W; i++) begin
      check("R5 tx enable", dx_oe, 2'b11);
      check("R5 R6 tx bit", dx, {exp_sr[2*W-1-i], exp_sr[W-1-i]});
      b = {rxv[2*W-1-i], rxv[W-1-i]};
      dr = b; sclk_in = 1'b0; tick(); tick();
      dr = ~b; sclk_in = 1'b1; tick(); tick();
    end
    check("R5 tx released", dx_oe, 2'b00);
    check("R7 no early commit", rx_valid, 1'b0);
    fsr_n = 1'b1; fsx_n = 1'b1; tick();
    check("R7 rx_valid", rx_valid, 1'b1);
    check("R7 R10 rx data", rx_data, rxv);
    check("R6 tx_taken", tx_taken, 1'b1);
    tick();
    check("R7 single pulse", rx_valid, 1'b0);
    exp_sr = nxt;
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cur_tx = 16'hA53C; tx_data = cur_tx; exp_sr = '0;
    repeat (3) @(negedge clk);
    check("R8 reset enables", {sclk_oe, dx_oe, frame_out}, '0);
    check("R8 reset strobes", {rx_valid, tx_taken}, '0);
    check("R8 reset rx data", rx_data, '0);
    rst_n = 1'b1; k = 0; drive_dr();
    run_int(3 * P + 3 * DIV + 1);
    check("R4 mid-transfer", dx_oe, 2'b11);
    ext_mode = 1'b1; sclk_in = 1'b0; tick();
    check("R9 abort on switch", dx_oe, 2'b00);
    check("R2 ext no clock", {sclk_oe, frame_out}, 2'b00);
    ext_xfer(16'h81E7, 16'h3C96);
    ext_xfer(16'h5AF0, 16'hC30F);
    fsr_n = 1'b0; tick();
    for (int i = 0; i < 3; i++) begin
      sclk_in = 1'b0; tick(); tick();
      sclk_in = 1'b1; tick(); tick();
      check("R10 rx strobe leaves tx idle", dx_oe, 2'b00);
    end
    fsr_n = 1'b1; tick();
    check("R7 partial commit strobe", rx_valid, 1'b1);
    check("R10 no tx capture", tx_taken, 1'b0);
    ext_mode = 1'b0; dr = '0; k = -1;
    run_int(P + W * DIV + DIV);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule